// File: doc/BRIEF.md
# Memory Version Tag Checker

This block sits on a tagged-memory access path. It compares the small version tag carried in the top bits of each pointer with a tag kept per memory granule, and returns a verdict for every access. There are four verdicts: grant, precise trap, deferred error, or data-access exception. A trap code and a reported address come with each verdict. The block also serves the operations that maintain the tag store: setting the tag of one granule, and clearing all tags of one page.

Requests arrive on a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its verdict appears on the result stream one cycle later. `req_ready` stays low while a result waits with `res_ready` low, so a stalled consumer holds back the producer. The result stays unchanged until it is taken.

Two inputs stay plain levels and are sampled when a request is taken: the task-level enable `task_en` and the store precision control `precise_mode`. A deferred store error captures the PC of the store that caused it. This record stays pending until software pulses `defer_ack`.

Top module: `tag_guard`

## Requirements
- R1: A load or store whose pointer tag (address bits 63:60) equals the stored tag of its granule, with `req_page_en` and `task_en` both 1, gets kind GRANT (0), code 0x00 and address 0.
- R2: Tags are held per 64-byte granule (granule index = address bits above 5). A tag-set (op 3) with `task_en`=1 writes `req_set_tag` to exactly the addressed granule and returns GRANT. Any later access, including the very next request, sees the new value.
- R3: When either `req_page_en` or `task_en` is 0, loads and stores get GRANT with no tag comparison.
- R4: Pointer tags 0x0 and 0xF match any stored tag.
- R5: A mismatching load (op 0) gets kind PRECISE (1) with code 0x1A and reports the full pointer as the address.
- R6: A non-faulting load (op 2) always gets GRANT, whatever its tag.
- R7: A mismatching store (op 1) with `precise_mode`=1 gets PRECISE, code 0x1A, and reports the pointer.
- R8: A mismatching store with `precise_mode`=0 gets kind DEFER (2) with code 0x7E. When no error is pending, it reports its own `req_pc` and, once taken, sets `defer_pending` and `defer_pc`.
- R9: While an error is pending, a later deferred store reports the held PC and leaves it unchanged. A `defer_ack` pulse clears the pending flag.
- R10: A tag-set with `task_en`=0 gets kind DAE (3), code 0x0A, reports the pointer, and writes no tag.
- R11: A page clear (op 4) gets GRANT and sets the tags of every granule in the 4 KiB page of `req_addr` to 0. Tags in other pages are left as they were.
- R12: While `res_valid` is 1 and `res_ready` is 0, `req_ready` is 0 and the result outputs stay unchanged.
- R13: After reset, `res_valid` and `defer_pending` are 0, `req_ready` is 1, and all stored tags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 3 | 0 load, 1 store, 2 non-faulting load, 3 tag-set, 4 page clear |
| req_addr | input | 64 | Pointer; bits 63:60 are the pointer tag |
| req_pc | input | 64 | PC of the access |
| req_set_tag | input | 4 | Tag written by a tag-set |
| req_page_en | input | 1 | Page-level check enable from the translation entry |
| task_en | input | 1 | Task-level master check enable |
| precise_mode | input | 1 | Store mismatches trap precisely when 1 |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result taken |
| res_kind | output | 2 | 0 grant, 1 precise, 2 deferred, 3 data-access exception |
| res_code | output | 8 | Trap type or fault type |
| res_addr | output | 64 | Faulting pointer, held PC, or 0 |
| defer_pending | output | 1 | A deferred error is pending |
| defer_pc | output | 64 | PC held for the pending error |
| defer_ack | input | 1 | Clears the pending error |

## Verification
Every verdict is due exactly one clock after the edge that takes its request. Tag writes and page clears take effect at that same edge. The deferred record changes at the edge that takes a DEFER result, and an acknowledge takes effect at the edge on which it is seen.

The bench drives on falling edges and reads the verdict on the falling edge that follows the taking edge. It reads the pending record one falling edge after the result is consumed. The stall test holds `res_ready` low across two falling edges before it releases it.

// File: rtl/tag_guard_pkg.sv
package tag_guard_pkg;
  localparam int ADDR_W = 64;
  localparam int TAG_W  = 4;

  typedef enum logic [2:0] {
    OP_LOAD    = 3'd0,
    OP_STORE   = 3'd1,
    OP_NFLOAD  = 3'd2,
    OP_SETTAG  = 3'd3,
    OP_CLRPAGE = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    RES_GRANT   = 2'd0,
    RES_PRECISE = 2'd1,
    RES_DEFER   = 2'd2,
    RES_DAE     = 2'd3
  } res_e;

  localparam logic [7:0] TT_PRECISE = 8'h1A;
  localparam logic [7:0] TT_DEFER   = 8'h7E;
  localparam logic [7:0] FT_BAD_ASI = 8'h0A;

  typedef struct packed {
    op_e               op;
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] pc;
    logic              page_en;
    logic              task_en;
    logic              precise;
  } acc_t;
endpackage

// File: rtl/tag_guard_ram.sv
module tag_guard_ram #(
  parameter int IDX_W   = 8,
  parameter int PG_W    = 2,
  parameter int TAG_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             clr_en,
  input  logic [PG_W-1:0]  clr_page
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int PG_LO = IDX_W - PG_W;

  logic [TAG_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam logic [IDX_W-1:0] GI = IDX_W'(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[g] <= '0;
      else if (clr_en && GI[IDX_W-1:PG_LO] == clr_page)
        mem[g] <= '0;
      else if (wr_en && wr_idx == GI)
        mem[g] <= wr_tag;
    end
  end

  // read register, loaded only when a request is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_tag <= '0;
    else if (rd_en)
      rd_tag <= mem[rd_idx];
  end
endmodule

// File: rtl/tag_guard_eval.sv
module tag_guard_eval
  import tag_guard_pkg::*;
(
  input  acc_t              acc,
  input  logic [TAG_W-1:0]  mem_tag,
  input  logic              held_valid,
  input  logic [ADDR_W-1:0] held_pc,
  output res_e              kind,
  output logic [7:0]        code,
  output logic [ADDR_W-1:0] addr,
  output logic              defer_hit
);
  logic [TAG_W-1:0] ptr_tag;
  logic             wild;
  logic             checked;
  logic             mism;

  always_comb begin
    ptr_tag   = acc.addr[ADDR_W-1 -: TAG_W];
    wild      = (ptr_tag == '0) || (ptr_tag == '1);
    checked   = acc.page_en && acc.task_en &&
                (acc.op == OP_LOAD || acc.op == OP_STORE);
    mism      = checked && !wild && (ptr_tag != mem_tag);
    kind      = RES_GRANT;
    code      = 8'h00;
    addr      = '0;
    defer_hit = 1'b0;
    case (acc.op)
      OP_SETTAG: if (!acc.task_en) begin
        kind = RES_DAE;
        code = FT_BAD_ASI;
        addr = acc.addr;
      end
      OP_LOAD: if (mism) begin
        kind = RES_PRECISE;
        code = TT_PRECISE;
        addr = acc.addr;
      end
      OP_STORE: if (mism) begin
        if (acc.precise) begin
          kind = RES_PRECISE;
          code = TT_PRECISE;
          addr = acc.addr;
        end else begin
          kind      = RES_DEFER;
          code      = TT_DEFER;
          addr      = held_valid ? held_pc : acc.pc;
          defer_hit = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tag_guard_defer.sv
module tag_guard_defer #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic              ack,
  output logic              pending,
  output logic [ADDR_W-1:0] pc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      pc      <= '0;
    end else if (capture && (!pending || ack)) begin
      pending <= 1'b1;
      pc      <= pc_in;
    end else if (ack) begin
      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/tag_guard.sv
module tag_guard
  import tag_guard_pkg::*;
#(
  parameter int GRAN_BITS = 6,
  parameter int PAGE_BITS = 12,
  parameter int IDX_W     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_op,
  input  logic [63:0] req_addr,
  input  logic [63:0] req_pc,
  input  logic [3:0]  req_set_tag,
  input  logic        req_page_en,
  input  logic        task_en,
  input  logic        precise_mode,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [1:0]  res_kind,
  output logic [7:0]  res_code,
  output logic [63:0] res_addr,
  output logic        defer_pending,
  output logic [63:0] defer_pc,
  input  logic        defer_ack
);
  localparam int PG_IN_IDX = PAGE_BITS - GRAN_BITS;
  localparam int PG_W      = IDX_W - PG_IN_IDX;

  logic             take;
  logic             stg_valid;
  acc_t             stg;
  op_e              in_op;
  logic [IDX_W-1:0] in_idx;
  logic [TAG_W-1:0] mem_tag;
  res_e             ev_kind;
  logic             ev_defer;
  logic             capture;

  assign in_op     = op_e'(req_op);
  assign in_idx    = req_addr[GRAN_BITS +: IDX_W];
  assign req_ready = !stg_valid || res_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_valid <= 1'b0;
      stg       <= '0;
    end else if (take) begin
      stg_valid   <= 1'b1;
      stg.op      <= in_op;
      stg.addr    <= req_addr;
      stg.pc      <= req_pc;
      stg.page_en <= req_page_en;
      stg.task_en <= task_en;
      stg.precise <= precise_mode;
    end else if (res_ready) begin
      stg_valid <= 1'b0;
    end
  end

  tag_guard_ram #(.IDX_W(IDX_W), .PG_W(PG_W), .TAG_W(TAG_W)) u_ram (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (take),
    .rd_idx   (in_idx),
    .rd_tag   (mem_tag),
    .wr_en    (take && in_op == OP_SETTAG && task_en),
    .wr_idx   (in_idx),
    .wr_tag   (req_set_tag),
    .clr_en   (take && in_op == OP_CLRPAGE),
    .clr_page (req_addr[PAGE_BITS +: PG_W])
  );

  tag_guard_eval u_eval (
    .acc        (stg),
    .mem_tag    (mem_tag),
    .held_valid (defer_pending && !defer_ack),
    .held_pc    (defer_pc),
    .kind       (ev_kind),
    .code       (res_code),
    .addr       (res_addr),
    .defer_hit  (ev_defer)
  );

  assign capture   = stg_valid && res_ready && ev_defer;
  assign res_valid = stg_valid;
  assign res_kind  = ev_kind;

  tag_guard_defer #(.ADDR_W(ADDR_W)) u_defer (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .pc_in   (stg.pc),
    .ack     (defer_ack),
    .pending (defer_pending),
    .pc      (defer_pc)
  );
endmodule

// File: rtl/tag_guard_props.sv
module tag_guard_props (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [2:0]  req_op,
  input logic        req_page_en,
  input logic        task_en,
  input logic        res_valid,
  input logic        res_ready,
  input logic [1:0]  res_kind,
  input logic [7:0]  res_code,
  input logic [63:0] res_addr,
  input logic        defer_pending,
  input logic [63:0] defer_pc,
  input logic        defer_ack
);
  logic [2:0] seen_op;
  logic       seen_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_op <= 3'd0;
      seen_on <= 1'b0;
    end else if (req_valid && req_ready) begin
      seen_op <= req_op;
      seen_on <= req_page_en && task_en;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready && !defer_ack |=> res_valid && $stable(res_kind) && $stable(res_addr)); // R12
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !req_ready); // R12
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    defer_pending && !defer_ack |=> defer_pending && $stable(defer_pc)); // R9
  AST_NF_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && seen_op == 3'd2 |-> res_kind == 2'd0); // R6
  AST_OFF_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !seen_on && seen_op <= 3'd1 |-> res_kind == 2'd0); // R3
  AST_PRECISE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_kind == 2'd1 |-> res_code == 8'h1A); // R5
  AST_DEFER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready && res_kind == 2'd2 |=> defer_pending); // R8
endmodule

bind tag_guard tag_guard_props u_props (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_op        (req_op),
  .req_page_en   (req_page_en),
  .task_en       (task_en),
  .res_valid     (res_valid),
  .res_ready     (res_ready),
  .res_kind      (res_kind),
  .res_code      (res_code),
  .res_addr      (res_addr),
  .defer_pending (defer_pending),
  .defer_pc      (defer_pc),
  .defer_ack     (defer_ack)
);

// File: tb/tag_guard_bench.sv
`timescale 1ns/1ps
module tag_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [63:0] req_addr = '0;
  logic [63:0] req_pc = '0;
  logic [3:0]  req_set_tag = '0;
  logic        req_page_en = 1'b0;
  logic        task_en = 1'b0;
  logic        precise_mode = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [1:0]  res_kind;
  logic [7:0]  res_code;
  logic [63:0] res_addr;
  logic        defer_pending;
  logic [63:0] defer_pc;
  logic        defer_ack = 1'b0;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tag_guard u_tag_guard (.*);

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  op;
    logic        te;
    logic        me;
    logic        pr;
    logic [3:0]  stag;
    logic [63:0] addr;
    logic [63:0] pc;
    logic [1:0]  kind;
    logic [7:0]  code;
    logic [63:0] eaddr;
  } vec_t;

  localparam int NV = 18;
  localparam logic [215:0] VEC [NV] = '{
    // R2 tag-set 0xA on granule 0x1040
    {4'd2,  3'd3, 1'b0, 1'b1, 1'b0, 4'hA, 64'hA000_0000_0000_1040, 64'h0, 2'd0, 8'h00, 64'h0},
    // R2 tag-set 0x6 on granule 0x2080 (other page)
    {4'd2,  3'd3, 1'b0, 1'b1, 1'b0, 4'h6, 64'h6000_0000_0000_2080, 64'h0, 2'd0, 8'h00, 64'h0},
    // R1 matching load
    {4'd1,  3'd0, 1'b1, 1'b1, 1'b0, 4'h0, 64'hA000_0000_0000_1040, 64'h0, 2'd0, 8'h00, 64'h0},
    // R5 mismatching load
    {4'd5,  3'd0, 1'b1, 1'b1, 1'b0, 4'h0, 64'h3000_0000_0000_1040, 64'h0, 2'd1, 8'h1A, 64'h3000_0000_0000_1040},
    // R4 wildcard 0x0
    {4'd4,  3'd0, 1'b1, 1'b1, 1'b0, 4'h0, 64'h0000_0000_0000_1040, 64'h0, 2'd0, 8'h00, 64'h0},
    // R4 wildcard 0xF
    {4'd4,  3'd0, 1'b1, 1'b1, 1'b0, 4'h0, 64'hF000_0000_0000_1040, 64'h0, 2'd0, 8'h00, 64'h0},
    // R6 non-faulting load
    {4'd6,  3'd2, 1'b1, 1'b1, 1'b0, 4'h0, 64'h3000_0000_0000_1040, 64'h0, 2'd0, 8'h00, 64'h0},
    // R3 page enable off
    {4'd3,  3'd0, 1'b0, 1'b1, 1'b0, 4'h0, 64'h3000_0000_0000_1040, 64'h0, 2'd0, 8'h00, 64'h0},
    // R3 task enable off
    {4'd3,  3'd1, 1'b1, 1'b0, 1'b0, 4'h0, 64'h3000_0000_0000_1040, 64'h0, 2'd0, 8'h00, 64'h0},
    // R7 precise store
    {4'd7,  3'd1, 1'b1, 1'b1, 1'b1, 4'h0, 64'h3000_0000_0000_1040, 64'h0, 2'd1, 8'h1A, 64'h3000_0000_0000_1040},
    // R8 deferred store reports its PC
    {4'd8,  3'd1, 1'b1, 1'b1, 1'b0, 4'h0, 64'h3000_0000_0000_1040, 64'h0000_0000_0040_0100, 2'd2, 8'h7E, 64'h0000_0000_0040_0100},
    // R9 second deferred store reports the held PC
    {4'd9,  3'd1, 1'b1, 1'b1, 1'b0, 4'h0, 64'h5000_0000_0000_1040, 64'h0000_0000_0040_0200, 2'd2, 8'h7E, 64'h0000_0000_0040_0100},
    // R10 tag-set with task enable off
    {4'd10, 3'd3, 1'b0, 1'b0, 1'b0, 4'h5, 64'h5000_0000_0000_1040, 64'h0, 2'd3, 8'h0A, 64'h5000_0000_0000_1040},
    // R10 tag was not written
    {4'd10, 3'd0, 1'b1, 1'b1, 1'b0, 4'h0, 64'h5000_0000_0000_1040, 64'h0, 2'd1, 8'h1A, 64'h5000_0000_0000_1040},
    // R2 neighbour granule untouched
    {4'd2,  3'd0, 1'b1, 1'b1, 1'b0, 4'h0, 64'hA000_0000_0000_1080, 64'h0, 2'd1, 8'h1A, 64'hA000_0000_0000_1080},
    // R11 page clear
    {4'd11, 3'd4, 1'b0, 1'b1, 1'b0, 4'h0, 64'h0000_0000_0000_1000, 64'h0, 2'd0, 8'h00, 64'h0},
    // R11 cleared granule now holds 0
    {4'd11, 3'd0, 1'b1, 1'b1, 1'b0, 4'h0, 64'hA000_0000_0000_1040, 64'h0, 2'd1, 8'h1A, 64'hA000_0000_0000_1040},
    // R11 other page kept
    {4'd11, 3'd0, 1'b1, 1'b1, 1'b0, 4'h0, 64'h6000_0000_0000_2080, 64'h0, 2'd0, 8'h00, 64'h0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_op       = v.op;
    req_page_en  = v.te;
    task_en      = v.me;
    precise_mode = v.pr;
    req_set_tag  = v.stag;
    req_addr     = v.addr;
    req_pc       = v.pc;
    req_valid    = 1'b1;
  endtask

  task automatic run_one(input vec_t v);
    string r;
    @(negedge clk);
    drive(v);
    @(negedge clk);
    req_valid = 1'b0;
    r = $sformatf("R%0d", v.req);
    chk({r, " valid"}, 64'(res_valid), 64'd1);
    chk({r, " kind"}, 64'(res_kind), 64'(v.kind));
    chk({r, " code"}, 64'(res_code), 64'(v.code));
    chk({r, " addr"}, res_addr, v.eaddr);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    vec_t v;
    // R13 reset state
    #1;
    chk("R13 valid in reset", 64'(res_valid), 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 valid", 64'(res_valid), 64'd0);
    chk("R13 ready", 64'(req_ready), 64'd1);
    chk("R13 pending", 64'(defer_pending), 64'd0);

    for (int i = 0; i < NV; i++) run_one(vec_t'(VEC[i]));

    @(negedge clk);
    chk("R9 pending held", 64'(defer_pending), 64'd1);
    chk("R9 held pc", defer_pc, 64'h0000_0000_0040_0100);
    defer_ack = 1'b1;
    @(negedge clk);
    defer_ack = 1'b0;
    chk("R9 ack clears", 64'(defer_pending), 64'd0);

    // R8 new capture after acknowledge
    v = '0;
    v.req = 4'd8; v.op = 3'd1; v.te = 1'b1; v.me = 1'b1;
    v.addr = 64'h3000_0000_0000_1040; v.pc = 64'h0000_0000_0040_0300;
    v.kind = 2'd2; v.code = 8'h7E; v.eaddr = 64'h0000_0000_0040_0300;
    run_one(v);
    @(negedge clk);
    chk("R8 pending set", 64'(defer_pending), 64'd1);
    chk("R8 captured pc", defer_pc, 64'h0000_0000_0040_0300);

    // R12 stall: result held, input blocked
    res_ready = 1'b0;
    v = '0;
    v.op = 3'd0; v.te = 1'b1; v.me = 1'b1; v.addr = 64'h3000_0000_0000_1040;
    drive(v);
    @(negedge clk);
    v.addr = 64'h6000_0000_0000_2080;
    drive(v);
    chk("R12 valid", 64'(res_valid), 64'd1);
    chk("R12 ready low", 64'(req_ready), 64'd0);
    @(negedge clk);
    chk("R12 still valid", 64'(res_valid), 64'd1);
    chk("R12 kind held", 64'(res_kind), 64'd1);
    chk("R12 addr held", res_addr, 64'h3000_0000_0000_1040);
    res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 next valid", 64'(res_valid), 64'd1);
    chk("R12 next kind", 64'(res_kind), 64'd0);
    chk("R12 next addr", res_addr, 64'h0);
    @(negedge clk);
    chk("R12 drained", 64'(res_valid), 64'd0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule